// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter whose control registers are guarded against stray writes. Three registers can be changed only through an unlock sequence: the expiry status, the match value and the match-enable pair. Software first writes a first key to one key address, then a second key to another key address. Only the single write that comes right after a correct pair reaches a protected register. Any other write closes the lock again.

Once matching is enabled, the counter advances by one on every functional clock. When the count equals the programmed match value, the counter wraps to zero and a sticky expiry status bit is set. If reset generation is also enabled, the block raises a registered reset request for a fixed number of cycles. The request reaches the system-reset output only while an external reset-gate enable input is high; that input stands in for the power-management control of the reset path.

The key sequencer is a three-state machine. SHUT moves to HALF on a first-key write. HALF moves to OPEN on a second-key write and falls back to SHUT on any other write. OPEN returns to SHUT on any write, and commits that write when it targets a protected address. The reset pulse generator is a two-state machine. IDLE moves to DRIVE on a match while reset generation is enabled. DRIVE returns to IDLE once its length counter runs out, and reloads the counter if another match arrives.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the lock state reads 0 (SHUT), status reads 0, the match value reads all ones, match-enable reads 0, the count reads 0 and `sys_rst_req` is low.
- R2: Address map: 0 = first key (reads back the lock state: 0 SHUT, 1 HALF, 2 OPEN), 1 = second key (reads 0), 2 = status (bit 0), 3 = match value, 4 = match-enable (bit 0 matching, bit 1 reset generation), 5 = count (read only). Writing 0xBABA to address 0 from SHUT and then 0xEB10 to address 1 gives OPEN, one cycle after each write.
- R3: A wrong key value, a key at the wrong address or out of order, or any other write from HALF returns the lock to SHUT. A write to addresses 2, 3 or 4 while not OPEN leaves that register unchanged.
- R4: Every write made in OPEN returns the lock to SHUT, so each protected write needs a fresh key pair.
- R5: A committed write to the status address with bit 0 equal to 0 clears the status bit; with bit 0 equal to 1 it leaves the bit unchanged. A match in the same cycle sets the bit and wins.
- R6: A committed write to the match-value address loads the new value and restarts the count at 0 on the next cycle.
- R7: The count rises by one per cycle only while match-enable bit 0 is set. Otherwise it holds.
- R8: When matching is enabled and the count equals the match value, the count reads 0 and status reads 1 on the next cycle.
- R9: A match with match-enable bit 1 set drives the internal reset request high for exactly 4 cycles, starting on the next cycle. A later match reloads the length. Without bit 1, no request is raised.
- R10: `sys_rst_req` is high only while the internal request is high and `rst_gate_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Register read data, combinational from the current state |
| rst_gate_en | input | 1 | External enable that lets the reset request leave the block |
| sys_rst_req | output | 1 | Gated system reset request |

## Verification
Every register result is due one clock after the write or match that causes it. These results are the lock state, the status bit, the match value, the enable bits and the count. The reset request rises one clock after the match and stays high for four cycles. The bench applies its inputs just after a rising edge and reads `rd_data` and `sys_rst_req` at the falling edge. Its reference model updates at the same rising edge, so each comparison falls in the first cycle where the new value is due. A rotating read address sweeps all six registers, and the reset-request cycles are counted per phase against the expected totals.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam logic [15:0] KEY_FIRST  = 16'hBABA;
    localparam logic [15:0] KEY_SECOND = 16'hEB10;

    typedef enum logic [2:0] {
        A_KEY1  = 3'd0,
        A_KEY2  = 3'd1,
        A_STAT  = 3'd2,
        A_MATCH = 3'd3,
        A_MEN   = 3'd4,
        A_COUNT = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        LK_SHUT = 2'd0,
        LK_HALF = 2'd1,
        LK_OPEN = 2'd2
    } lock_e;

    typedef enum logic {
        PL_IDLE  = 1'b0,
        PL_DRIVE = 1'b1
    } pulse_e;

    localparam int MEN_W = 2;

endpackage

// File: rtl/kwdt_key_seq.sv
module kwdt_key_seq
    import kwdt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output lock_e             lock_st,
    output logic              commit
);

    localparam logic [DATA_W-1:0] K1 = DATA_W'(KEY_FIRST);
    localparam logic [DATA_W-1:0] K2 = DATA_W'(KEY_SECOND);

    lock_e cur, nxt;
    logic  is_prot;
    logic  first_ok;
    logic  second_ok;

    assign first_ok  = (wr_addr == A_KEY1) && (wr_data == K1);
    assign second_ok = (wr_addr == A_KEY2) && (wr_data == K2);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= LK_SHUT;
        end else begin
            cur <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = cur;
        if (wr_en) begin
            unique case (cur)
                LK_SHUT: nxt = first_ok  ? LK_HALF : LK_SHUT;
                LK_HALF: nxt = second_ok ? LK_OPEN : LK_SHUT;
                LK_OPEN: nxt = LK_SHUT;
                default: nxt = LK_SHUT;
            endcase
        end
    end

    // outputs
    always_comb begin
        is_prot = (wr_addr == A_STAT) || (wr_addr == A_MATCH) ||
                  (wr_addr == A_MEN);
        commit  = wr_en && (cur == LK_OPEN) && is_prot;
        lock_st = cur;
    end

endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int          CNT_W     = 16,
    parameter logic [CNT_W-1:0] MATCH_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             hit,
    output logic             status_q,
    output logic [CNT_W-1:0] match_q,
    output logic [MEN_W-1:0] men_q,
    output logic             restart
);

    logic wr_stat, wr_match, wr_men;

    assign wr_stat  = commit && (wr_addr == A_STAT);
    assign wr_match = commit && (wr_addr == A_MATCH);
    assign wr_men   = commit && (wr_addr == A_MEN);
    assign restart  = wr_match;

    // sticky expiry flag: a match wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (hit) begin
            status_q <= 1'b1;
        end else if (wr_stat && !wr_val[0]) begin
            status_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= MATCH_RST;
        end else if (wr_match) begin
            match_q <= wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            men_q <= '0;
        end else if (wr_men) begin
            men_q <= wr_val[MEN_W-1:0];
        end
    end

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             hit
);

    assign hit = run && (count == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else if (run) begin
            if (hit) begin
                count <= '0;
            end else begin
                count <= count + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse
    import kwdt_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic req_q
);

    localparam int PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [PW-1:0] LOAD = PW'(PULSE_LEN - 1);

    pulse_e         cur, nxt;
    logic [PW-1:0]  left_q, left_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur    <= PL_IDLE;
            left_q <= '0;
        end else begin
            cur    <= nxt;
            left_q <= left_n;
        end
    end

    // transitions
    always_comb begin
        nxt    = cur;
        left_n = left_q;
        unique case (cur)
            PL_IDLE: begin
                if (trig) begin
                    nxt    = PL_DRIVE;
                    left_n = LOAD;
                end
            end
            PL_DRIVE: begin
                if (trig) begin
                    left_n = LOAD;
                end else if (left_q == '0) begin
                    nxt = PL_IDLE;
                end else begin
                    left_n = left_q - PW'(1);
                end
            end
            default: begin
                nxt    = PL_IDLE;
                left_n = '0;
            end
        endcase
    end

    // registered output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= (nxt == PL_DRIVE);
        end
    end

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwdt_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rst_gate_en,
    output logic              sys_rst_req
);

    localparam int CNT_W = DATA_W;

    lock_e            lock_q;
    logic             commit;
    logic             status_q;
    logic [CNT_W-1:0] match_q;
    logic [MEN_W-1:0] men_q;
    logic             restart;
    logic [CNT_W-1:0] cnt_q;
    logic             hit;
    logic             req_q;

    kwdt_key_seq #(.DATA_W(DATA_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .lock_st (lock_q),
        .commit  (commit)
    );

    kwdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .wr_addr  (wr_addr),
        .wr_val   (wr_data),
        .hit      (hit),
        .status_q (status_q),
        .match_q  (match_q),
        .men_q    (men_q),
        .restart  (restart)
    );

    kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (men_q[0]),
        .restart (restart),
        .limit   (match_q),
        .count   (cnt_q),
        .hit     (hit)
    );

    kwdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (hit && men_q[1]),
        .req_q (req_q)
    );

    assign sys_rst_req = req_q && rst_gate_en;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_KEY1:  rd_data = DATA_W'(lock_q);
            A_STAT:  rd_data = DATA_W'(status_q);
            A_MATCH: rd_data = match_q;
            A_MEN:   rd_data = DATA_W'(men_q);
            A_COUNT: rd_data = cnt_q;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk
    import kwdt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rst_gate_en,
    input logic              sys_rst_req,
    input lock_e             lock_q,
    input logic              commit,
    input logic              status_q,
    input logic [DATA_W-1:0] match_q,
    input logic [1:0]        men_q,
    input logic [DATA_W-1:0] cnt_q,
    input logic              req_q
);

    logic match_wr;
    assign match_wr = commit && (wr_addr == A_MATCH);

    // R2
    a_r2_second_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && lock_q == LK_HALF && wr_addr == A_KEY2 &&
        wr_data == DATA_W'(KEY_SECOND) |=> lock_q == LK_OPEN);

    // R3
    a_r3_locked_match_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && lock_q != LK_OPEN && wr_addr == A_MATCH |=> $stable(match_q));

    // R4
    a_r4_single_use: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> lock_q == LK_SHUT);

    // R6
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        match_wr |=> cnt_q == '0);

    // R7
    a_r7_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !men_q[0] && !match_wr |=> $stable(cnt_q));

    // R8
    a_r8_wrap_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        men_q[0] && cnt_q == match_q && !match_wr |=> cnt_q == '0 && status_q);

    // R9
    a_r9_no_req_without_arm: assert property (@(posedge clk) disable iff (!rst_n)
        !req_q && !(men_q[0] && men_q[1] && cnt_q == match_q) |=> !req_q);

    // R9
    a_r9_pulse_continues: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |=> req_q);

    // R10
    a_r10_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_gate_en |-> !sys_rst_req);

endmodule

bind keyed_watchdog keyed_watchdog_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rst_gate_en (rst_gate_en),
    .sys_rst_req (sys_rst_req),
    .lock_q      (lock_q),
    .commit      (commit),
    .status_q    (status_q),
    .match_q     (match_q),
    .men_q       (men_q),
    .cnt_q       (cnt_q),
    .req_q       (req_q)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;

    localparam int CLK_PER = 10;
    localparam int DW      = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [2:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          rst_gate_en = 1'b1;
    logic          sys_rst_req;

    int n_vec  = 0;
    int n_bad  = 0;
    int highs  = 0;
    bit done   = 0;
    string tag = "R1";

    // reference model state
    int m_lock = 0, m_stat = 0, m_match = 16'hFFFF, m_men = 0, m_cnt = 0, m_left = 0;

    keyed_watchdog u_keyed_watchdog (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .rst_gate_en (rst_gate_en),
        .sys_rst_req (sys_rst_req)
    );

    always #(CLK_PER/2) clk = ~clk;

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lock = 0; m_stat = 0; m_match = 16'hFFFF; m_men = 0; m_cnt = 0; m_left = 0;
        end else begin
            bit hit_now, com;
            hit_now = (m_men % 2 == 1) && (m_cnt == m_match);
            com = wr_en && m_lock == 2 && (wr_addr >= 2 && wr_addr <= 4);
            if (com && wr_addr == 3) m_cnt = 0;
            else if (m_men % 2 == 1) m_cnt = hit_now ? 0 : (m_cnt + 1) % 65536;
            if (hit_now) m_stat = 1;
            else if (com && wr_addr == 2 && wr_data[0] == 1'b0) m_stat = 0;
            if (com && wr_addr == 3) m_match = int'(wr_data);
            if (com && wr_addr == 4) m_men = int'(wr_data[1:0]);
            if (hit_now && m_men >= 2 && !(com && wr_addr == 4)) m_left = 4;
            else if (hit_now && (m_men >= 2)) m_left = 4;
            else if (m_left > 0) m_left = m_left - 1;
            if (wr_en) begin
                if (m_lock == 0) m_lock = (wr_addr == 0 && wr_data == 16'hBABA) ? 1 : 0;
                else if (m_lock == 1) m_lock = (wr_addr == 1 && wr_data == 16'hEB10) ? 2 : 0;
                else m_lock = 0;
            end
        end
    end

    function automatic int model_read(input int a);
        case (a)
            0: return m_lock;
            2: return m_stat;
            3: return m_match;
            4: return m_men;
            5: return m_cnt;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit m_req;
            m_req = (m_left > 0) && rst_gate_en;
            chk($sformatf("%s rd[%0d]", tag, rd_addr), int'(rd_data), model_read(int'(rd_addr)));
            chk($sformatf("%s sys_rst_req", tag), int'(sys_rst_req), int'(m_req));
        end
    end

    // read address sweep
    always @(posedge clk) begin
        #2 rd_addr <= (rd_addr == 3'd5) ? 3'd0 : rd_addr + 3'd1;
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            wr_en = 1'b0;
            #2 if (sys_rst_req) highs++;
        end
    endtask

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = DW'(d);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(0, 16'hBABA);
        wr(1, 16'hEB10);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tag = "R1";
        idle(8);
        chk("R1 req low after reset", int'(sys_rst_req), 0);

        tag = "R2";
        wr(0, 16'hBABA);
        wr(1, 16'hEB10);
        idle(6);
        tag = "R4";
        wr(3, 16'h000F);
        idle(6);

        tag = "R3";
        wr(4, 3);
        wr(0, 16'hBABA); wr(0, 16'hBABA); wr(1, 16'hEB10);
        wr(4, 3);
        wr(1, 16'hEB10); wr(0, 16'hBABA); wr(1, 16'h1234);
        wr(3, 16'h0002);
        idle(6);

        tag = "R7";
        unlock(); wr(4, 1);
        highs = 0;
        idle(40);
        chk("R9 no request with reset disabled", highs, 0);

        tag = "R5";
        unlock(); wr(2, 1);
        idle(3);
        unlock(); wr(2, 0);
        idle(6);

        tag = "R9";
        unlock(); wr(2, 0);
        unlock(); wr(4, 3);
        highs = 0;
        idle(40);
        chk("R9 request observed", int'(highs >= 4), 1);

        tag = "R10";
        rst_gate_en = 1'b0;
        highs = 0;
        idle(40);
        chk("R10 gate off blocks request", highs, 0);
        rst_gate_en = 1'b1;

        tag = "R6";
        unlock(); wr(3, 5);
        idle(20);
        unlock(); wr(4, 0);
        idle(10);

        tag = "R8";
        unlock(); wr(4, 3);
        unlock(); wr(3, 0);
        idle(12);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule